// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests for a single processor. It has twenty sources. Twelve are external lines that latch on a rising edge. Four are mailbox words that a register write raises. Four are reloading down-counters that raise a request each time they expire. Each source has its own configuration word. That word holds a 4-bit priority, a route, a mask bit and an 8-bit vector.

A combinational arbiter picks the most urgent eligible source. The winner is delivered only if its priority is strictly above two values: the programmed task priority and the priority at the top of an in-service stack. A delivered request drives exactly one of three outputs, chosen by the route of the winner: the standard line, the critical line or the off-chip pin.

Software uses a small register port. A read of the acknowledge register claims the winner. A write to the end-of-interrupt register closes the handler. A pending summary register shows every source in one word.

Top module: `nest_pic`

## Requirements
- R1: After reset all three request outputs are low, the pending summary reads 0, the task priority reads 0, and each configuration word holds priority 0, route 0, mask 0 and a vector equal to its source index.
- R2: A rising edge on external line i sets the pending bit of source i. The summary register (address 0x23) has one bit per source: line i at bit i, mailbox m at bit 12+m, timer t at bit 16+t. Pending bits show even when the source is masked or has priority 0.
- R3: The configuration word of source i is at address i. Its fields are priority [3:0], route [5:4], mask [6] and vector [14:7]. A source with priority 0 or with its mask bit set is never delivered.
- R4: Route 0 drives the standard output, route 1 drives the critical output, and routes 2 and 3 drive the external pin. Only the output of the winner's route rises; the other two stay low.
- R5: The winner is delivered only if its priority is strictly greater than the task priority (address 0x20, bits [3:0]) and strictly greater than the top of the in-service stack. An empty stack counts as 0.
- R6: When pending eligible sources share the highest priority, the one with the lower index wins.
- R7: A read of address 0x21 while a winner is delivered returns that winner's vector. The same read pushes the winner's priority onto the in-service stack and clears its pending bit. With nothing delivered, the read returns 0xFF and changes no state.
- R8: A write to address 0x22 pops the in-service stack. A write to 0x22 on an empty stack has no effect.
- R9: A write to mailbox m (address 0x24+m) stores the 32-bit word and sets its pending bit. A read of that address returns the stored word and clears the pending bit.
- R10: A write to timer t's base (address 0x28+t) loads both the base and the count. While its enable bit (address 0x2C, bit t) is set, the count falls by one each cycle. A count of 0 raises the timer's pending bit and reloads the base, so the first expiry comes base+1 cycles after the enable. A cleared enable holds the count.
- R11: Read data and its valid flag appear in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 12 | External request lines, rising-edge latched |
| reg_valid_i | input | 1 | Register access request this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| irq_std_o | output | 1 | Standard interrupt request to the processor |
| irq_crit_o | output | 1 | Critical interrupt request to the processor |
| irq_ext_o | output | 1 | Request for off-chip handling |

## Verification
The stack checks assume two things about software: it acknowledges only when a request is delivered, and it issues at most one register access per cycle. From those it follows that every push is strictly above the current top and that the stack can never overflow. The mailbox and edge-latch checks also rely on one access per cycle, so a write and a read of the same mailbox never collide. The bench drives its accesses through a single task, one at a time, and only claims requests through the acknowledge path. That keeps the stimulus inside these assumptions.

// File: rtl/nest_pic_pkg.sv
package nest_pic_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_TASK  = 8'h20;
  localparam logic [ADDR_W-1:0] A_ACK   = 8'h21;
  localparam logic [ADDR_W-1:0] A_EOI   = 8'h22;
  localparam logic [ADDR_W-1:0] A_SUM   = 8'h23;
  localparam logic [ADDR_W-1:0] A_MSG   = 8'h24;
  localparam logic [ADDR_W-1:0] A_TBASE = 8'h28;
  localparam logic [ADDR_W-1:0] A_TEN   = 8'h2C;

  localparam logic [VEC_W-1:0] SPURIOUS_VEC = 8'hFF;

  typedef enum logic [1:0] {
    RT_STD  = 2'd0,
    RT_CRIT = 2'd1,
    RT_OFF  = 2'd2,
    RT_OFF2 = 2'd3
  } route_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    logic              mask;
    route_e            route;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  // strictly above both the task level and the in-service level
  function automatic logic clears_bar(input logic [PRIO_W-1:0] p,
                                      input logic [PRIO_W-1:0] tsk,
                                      input logic [PRIO_W-1:0] top);
    return (p > tsk) && (p > top);
  endfunction

  // {off-chip, critical, standard}
  function automatic logic [2:0] route_lines(input route_e r);
    case (r)
      RT_STD:  return 3'b001;
      RT_CRIT: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction
endpackage

// File: rtl/nest_pic_arbiter.sv
module nest_pic_arbiter #(
  parameter int N_SRC  = 20,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             elig_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         win_valid_o,
  output logic [IDX_W-1:0]             win_idx_o,
  output logic [PRIO_W-1:0]            win_prio_o
);
  // scan from index 0 upward; only a strictly higher level replaces the
  // current pick, so equal levels keep the lower index
  always_comb begin
    logic              v;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] p;
    v   = 1'b0;
    idx = '0;
    p   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_i[i] && (!v || prio_i[i] > p)) begin
        v   = 1'b1;
        idx = IDX_W'(i);
        p   = prio_i[i];
      end
    end
    win_valid_o = v;
    win_idx_o   = idx;
    win_prio_o  = p;
  end
endmodule

// File: rtl/nest_pic_isr_stack.sv
module nest_pic_isr_stack #(
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [PRIO_W-1:0] top_prio_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][PRIO_W-1:0] stk_q;
  logic [CNT_W-1:0]             cnt_q;
  logic                         full, empty;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    top_prio_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (cnt_q == CNT_W'(k + 1)) top_prio_o = stk_q[k];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stk_q <= '0;
    end else if (push_i && !full) begin
      for (int k = 0; k < DEPTH; k++)
        if (cnt_q == CNT_W'(k)) stk_q[k] <= push_prio_i;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  push_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (push_prio_i > top_prio_o));
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full);
  // R8
  pop_lowers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty) |=> (top_prio_o < $past(top_prio_o)));
endmodule

// File: rtl/nest_pic_timer.sv
module nest_pic_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, base_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] b);
    return (c == '0) ? b : c - 1'b1;
  endfunction

  assign expire_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      base_q <= load_val_i;
    end else if (en_i) begin
      cnt_q  <= next_count(cnt_q, base_q);
    end
  end

  // R10
  load_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> !expire_o);
endmodule

// File: rtl/nest_pic.sv
module nest_pic
  import nest_pic_pkg::*;
#(
  parameter int N_EXT     = 12,
  parameter int N_MSG     = 4,
  parameter int N_TMR     = 4,
  parameter int TMR_W     = 32,
  parameter int ISR_DEPTH = 16,
  parameter int DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              reg_rvalid_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_std_o,
  output logic              irq_crit_o,
  output logic              irq_ext_o
);
  localparam int N_SRC  = N_EXT + N_MSG + N_TMR;
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int MSG_LO = N_EXT;
  localparam int TMR_LO = N_EXT + N_MSG;
  localparam int CFG_W  = $bits(src_cfg_t);

  src_cfg_t                     cfg_q [N_SRC];
  logic [N_SRC-1:0]             pend_q, set_vec, clr_vec;
  logic [N_EXT-1:0]             ext_q;
  logic [DATA_W-1:0]            msg_q [N_MSG];
  logic [PRIO_W-1:0]            task_q;
  logic [N_TMR-1:0]             tmr_en_q, tmr_fire;
  logic [DATA_W-1:0]            rd_mux, rdata_q;
  logic                         rvalid_q;

  // named internal events
  logic                         wr_en, rd_en, ack_rd, eoi_wr, ack_take, deliver;
  logic [N_SRC-1:0]             elig;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_vec;
  logic                         win_valid;
  logic [IDX_W-1:0]             win_idx;
  logic [PRIO_W-1:0]            win_prio, isr_top;
  logic [2:0]                   lines;

  assign wr_en  = reg_valid_i && reg_write_i;
  assign rd_en  = reg_valid_i && !reg_write_i;
  assign ack_rd = rd_en && (reg_addr_i == A_ACK);
  assign eoi_wr = wr_en && (reg_addr_i == A_EOI);

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      prio_vec[i] = cfg_q[i].prio;
      elig[i]     = pend_q[i] && !cfg_q[i].mask && (cfg_q[i].prio != '0);
    end
  end

  nest_pic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .elig_i     (elig),
    .prio_i     (prio_vec),
    .win_valid_o(win_valid),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  assign deliver  = win_valid && clears_bar(win_prio, task_q, isr_top);
  assign ack_take = ack_rd && deliver;

  nest_pic_isr_stack #(.DEPTH(ISR_DEPTH), .PRIO_W(PRIO_W)) u_isr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ack_take),
    .push_prio_i(win_prio),
    .pop_i      (eoi_wr),
    .top_prio_o (isr_top)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    logic ld;
    assign ld = wr_en && (reg_addr_i == ADDR_W'(A_TBASE + t));
    nest_pic_timer #(.CNT_W(TMR_W)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (tmr_en_q[t]),
      .load_i    (ld),
      .load_val_i(reg_wdata_i[TMR_W-1:0]),
      .expire_o  (tmr_fire[t])
    );
  end

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[N_EXT-1:0] = ext_irq_i & ~ext_q;
    for (int m = 0; m < N_MSG; m++) begin
      if (wr_en && reg_addr_i == ADDR_W'(A_MSG + m)) set_vec[MSG_LO+m] = 1'b1;
      if (rd_en && reg_addr_i == ADDR_W'(A_MSG + m)) clr_vec[MSG_LO+m] = 1'b1;
    end
    set_vec[TMR_LO +: N_TMR] = tmr_fire;
    if (ack_take) clr_vec[win_idx] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      ext_q    <= '0;
      task_q   <= '0;
      tmr_en_q <= '0;
      for (int i = 0; i < N_SRC; i++)
        cfg_q[i] <= '{vec: VEC_W'(i), mask: 1'b0, route: RT_STD, prio: '0};
      for (int m = 0; m < N_MSG; m++) msg_q[m] <= '0;
    end else begin
      pend_q <= set_vec | (pend_q & ~clr_vec);
      ext_q  <= ext_irq_i;
      if (wr_en) begin
        for (int i = 0; i < N_SRC; i++)
          if (reg_addr_i == ADDR_W'(i)) cfg_q[i] <= src_cfg_t'(reg_wdata_i[CFG_W-1:0]);
        for (int m = 0; m < N_MSG; m++)
          if (reg_addr_i == ADDR_W'(A_MSG + m)) msg_q[m] <= reg_wdata_i;
        if (reg_addr_i == A_TASK) task_q   <= reg_wdata_i[PRIO_W-1:0];
        if (reg_addr_i == A_TEN)  tmr_en_q <= reg_wdata_i[N_TMR-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_SRC; i++)
      if (reg_addr_i == ADDR_W'(i)) rd_mux = DATA_W'(cfg_q[i]);
    for (int m = 0; m < N_MSG; m++)
      if (reg_addr_i == ADDR_W'(A_MSG + m)) rd_mux = msg_q[m];
    if (reg_addr_i == A_TASK) rd_mux = DATA_W'(task_q);
    if (reg_addr_i == A_ACK)  rd_mux = deliver ? DATA_W'(cfg_q[win_idx].vec) : DATA_W'(SPURIOUS_VEC);
    if (reg_addr_i == A_SUM)  rd_mux = DATA_W'(pend_q);
    if (reg_addr_i == A_TEN)  rd_mux = DATA_W'(tmr_en_q);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign reg_rvalid_o = rvalid_q;
  assign reg_rdata_o  = rdata_q;

  assign lines      = deliver ? route_lines(cfg_q[win_idx].route) : 3'b000;
  assign irq_std_o  = lines[0];
  assign irq_crit_o = lines[1];
  assign irq_ext_o  = lines[2];

  // R3
  win_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (pend_q[win_idx] && !cfg_q[win_idx].mask && cfg_q[win_idx].prio != '0));
  // R11
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rvalid_o |-> $past(reg_valid_i && !reg_write_i));

  for (genvar e = 0; e < N_EXT; e++) begin : g_edge_chk
    // R2
    edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_irq_i[e] && !ext_q[e]) |=> pend_q[e]);
  end

  for (genvar m = 0; m < N_MSG; m++) begin : g_msg_chk
    // R9
    msg_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && reg_addr_i == ADDR_W'(A_MSG + m)) |=> pend_q[MSG_LO+m]);
  end
endmodule

// File: tb/nest_pic_tb.sv
`timescale 1ns/1ps
module nest_pic_tb;
  localparam logic [7:0] TASK_A = 8'h20, ACK_A = 8'h21, EOI_A = 8'h22, SUM_A = 8'h23;
  localparam logic [7:0] MBOX_A = 8'h24, TBASE_A = 8'h28, TEN_A = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ext;
  logic        valid, write;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        rvalid, o_std, o_crit, o_ext;
  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  nest_pic u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext),
    .reg_valid_i(valid), .reg_write_i(write), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rvalid_o(rvalid), .reg_rdata_o(rdata),
    .irq_std_o(o_std), .irq_crit_o(o_crit), .irq_ext_o(o_ext)
  );

  typedef struct packed {
    logic [4:0] src;
    logic [3:0] prio;
    logic [1:0] route;
    logic       mask;
    logic [3:0] tsk;
    logic [2:0] exp;   // {ext, crit, std}
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{5'd0,  4'd5,  2'd0, 1'b0, 4'd0,  3'b001},
    '{5'd3,  4'd5,  2'd1, 1'b0, 4'd0,  3'b010},
    '{5'd11, 4'd5,  2'd2, 1'b0, 4'd0,  3'b100},
    '{5'd7,  4'd9,  2'd3, 1'b0, 4'd0,  3'b100},
    '{5'd2,  4'd0,  2'd0, 1'b0, 4'd0,  3'b000},
    '{5'd4,  4'd7,  2'd0, 1'b1, 4'd0,  3'b000},
    '{5'd5,  4'd7,  2'd0, 1'b0, 4'd7,  3'b000},
    '{5'd6,  4'd8,  2'd1, 1'b0, 4'd7,  3'b010},
    '{5'd9,  4'd15, 2'd0, 1'b0, 4'd14, 3'b001},
    '{5'd1,  4'd1,  2'd2, 1'b0, 4'd0,  3'b100}
  };

  function automatic logic [31:0] lines();
    return {29'b0, o_ext, o_crit, o_std};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d, output logic rv);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    valid = 1'b0;
    d  = rdata;
    rv = rvalid;
  endtask

  task automatic cfg(input int src, input int prio, input int route, input int mask);
    reg_wr(8'(src), (32'(src) << 7) | (32'(mask) << 6) | (32'(route) << 4) | 32'(prio));
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk); ext = m;
    @(negedge clk); ext = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = 1'b0; write = 1'b0; addr = '0; wdata = '0; ext = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        rv;
    do_reset();

    // R1 reset state
    chk("R1 outputs", lines(), 32'h0);
    reg_rd(SUM_A, d, rv);  chk("R1 summary", d, 32'h0);
    reg_rd(8'd5, d, rv);   chk("R1 cfg5", d, 32'h0000_0280);
    reg_rd(TASK_A, d, rv); chk("R1 task", d, 32'h0);
    // R11 read timing
    chk("R11 rvalid with data", 32'(rv), 32'h1);
    @(negedge clk);
    chk("R11 rvalid drops", 32'(rvalid), 32'h0);

    // R3 R4 R5 table of route / threshold vectors, then R7 acknowledge
    for (int v = 0; v < 10; v++) begin
      do_reset();
      cfg(int'(TBL[v].src), int'(TBL[v].prio), int'(TBL[v].route), int'(TBL[v].mask));
      reg_wr(TASK_A, 32'(TBL[v].tsk));
      pulse(12'(1) << TBL[v].src);
      chk($sformatf("R3 R4 R5 vector %0d lines", v), lines(), 32'(TBL[v].exp));
      reg_rd(ACK_A, d, rv);
      chk($sformatf("R7 vector %0d ack", v), d,
          (TBL[v].exp != 3'b000) ? 32'(TBL[v].src) : 32'hFF);
    end

    // R5 nesting order
    do_reset();
    cfg(0, 4, 0, 0); cfg(1, 9, 0, 0); cfg(2, 6, 0, 0);
    pulse(12'h001);
    reg_rd(ACK_A, d, rv); chk("R5 nest ack low", d, 32'd0);
    pulse(12'h002);
    chk("R5 higher preempts", lines(), 32'h1);
    reg_rd(ACK_A, d, rv); chk("R5 nest ack high", d, 32'd1);
    pulse(12'h004);
    chk("R5 middle blocked in service", lines(), 32'h0);
    reg_wr(EOI_A, 0);
    chk("R8 pop exposes middle", lines(), 32'h1);
    reg_rd(ACK_A, d, rv); chk("R5 nest ack middle", d, 32'd2);
    reg_wr(EOI_A, 0); reg_wr(EOI_A, 0);
    reg_rd(SUM_A, d, rv); chk("R7 pending cleared by acks", d, 32'h0);

    // R8 pop on empty stack ignored
    do_reset();
    cfg(0, 3, 0, 0); cfg(1, 2, 0, 0);
    pulse(12'h001);
    reg_rd(ACK_A, d, rv);
    reg_wr(EOI_A, 0); reg_wr(EOI_A, 0);
    pulse(12'h002);
    chk("R8 empty pop no effect", lines(), 32'h1);

    // R6 tie goes to lower index
    do_reset();
    cfg(3, 5, 0, 0); cfg(8, 5, 0, 0);
    pulse(12'h108);
    reg_rd(ACK_A, d, rv); chk("R6 tie lower index", d, 32'd3);
    chk("R5 equal level blocked", lines(), 32'h0);
    reg_wr(EOI_A, 0);
    reg_rd(ACK_A, d, rv); chk("R6 tie second", d, 32'd8);

    // R2 masked source still visible in summary
    do_reset();
    cfg(10, 5, 0, 1);
    pulse(12'h400);
    chk("R3 masked no output", lines(), 32'h0);
    reg_rd(SUM_A, d, rv); chk("R2 masked pending visible", d, 32'h400);
    reg_rd(ACK_A, d, rv); chk("R7 spurious ack", d, 32'hFF);
    reg_rd(SUM_A, d, rv); chk("R7 spurious ack no effect", d, 32'h400);

    // R9 mailbox
    do_reset();
    cfg(12, 3, 1, 0);
    reg_wr(MBOX_A, 32'hDEAD_BEEF);
    chk("R9 mailbox raises critical", lines(), 32'h2);
    reg_rd(SUM_A, d, rv); chk("R9 summary bit 12", d, 32'h1000);
    reg_rd(MBOX_A, d, rv); chk("R9 mailbox data", d, 32'hDEAD_BEEF);
    chk("R9 read drops request", lines(), 32'h0);
    reg_rd(SUM_A, d, rv); chk("R9 pending cleared", d, 32'h0);

    // R10 timer 1 (source 17)
    do_reset();
    cfg(17, 2, 0, 0);
    reg_wr(TBASE_A + 8'd1, 32'd4);
    reg_wr(TEN_A, 32'h2);
    begin
      int n;
      n = 0;
      while (!o_std && n < 30) begin @(negedge clk); n++; end
      chk("R10 first expiry after base+1", 32'(n), 32'd5);
    end
    reg_rd(ACK_A, d, rv); chk("R10 timer vector", d, 32'd17);
    reg_wr(EOI_A, 0);
    begin
      int n;
      n = 0;
      while (!o_std && n < 30) begin @(negedge clk); n++; end
      chk("R10 reload refires", lines(), 32'h1);
    end
    reg_wr(TEN_A, 32'h0);
    reg_rd(ACK_A, d, rv);
    reg_wr(EOI_A, 0);
    repeat (20) @(negedge clk);
    reg_rd(SUM_A, d, rv); chk("R10 disabled holds", d, 32'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule